// File: doc/BRIEF.md
# Reset Cause Status Register

This block records why the most recent reset occurred and keeps that record across the reset it describes. It sits in the always-powered part of the chip. Seven single-cycle strobes arrive from the reset sources: the power-on detector, the two supply-monitor thresholds, the deep-standby wake path, the two watchdog timers and the external reset pin. The block updates six sticky flags from these strobes. Start-up software reads the flags, acts on them and then clears them.

The flags are presented as two read-only bytes, a status byte and a watchdog byte. A 3-bit cause code is also provided; it names the single most significant source by a fixed priority. Software clears flags through a valid/ready write channel. The block never applies back-pressure: `wr_ready` is always high, and a beat is taken on every clock edge where `wr_valid` is high. A beat's `wr_sel` picks the byte it addresses. Each 0 written over a flag clears that flag, and each 1 leaves it as it is. All updates take effect at the clock edge. The read bytes and the cause code follow one cycle later, with no further delay.

Top module: `rcs_status`

## Requirements
- R1: After `rst_n` is deasserted, every flag is 0, both bytes read 0x00 and `cause` is 0.
- R2: A power-on strobe sets the power-on flag (status bit 0) and clears all other flags on the next edge.
- R3: A threshold 1, threshold 2, deep-standby, independent watchdog or watchdog strobe sets its own flag and clears the power-on flag. Other flags keep their value. Flag positions: threshold 1 at status bit 1, threshold 2 at status bit 2, deep-standby at status bit 7, independent watchdog at watchdog-byte bit 0, watchdog at watchdog-byte bit 1.
- R4: A pin strobe clears every flag. A non-pin strobe in the same cycle is applied after the wipe and still sets its flag.
- R5: A write beat with `wr_sel`=0 clears each status flag whose bit in `wr_data` is 0. A 1 leaves the flag unchanged, and the data bits at positions 6:3 are ignored.
- R6: A write beat with `wr_sel`=1 clears the watchdog flag when data bit 1 is 0 and the independent watchdog flag when data bit 0 is 0. It leaves the status flags untouched.
- R7: A strobe and a write that clears the same flag in one cycle leave the flag set.
- R8: `cause` is 6 when the watchdog flag is set. Otherwise the code follows this order: independent watchdog 5, deep-standby 4, threshold 2 is 3, threshold 1 is 2, power-on 1. When no flag is set, the code is 0 (pin).
- R9: Status bits 6:3 and watchdog-byte bits 7:2 always read 0.
- R10: `wr_ready` is always 1. With `wr_valid` low, `wr_data` and `wr_sel` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on domain clock |
| rst_n | input | 1 | Active-low reset of the flag storage |
| evt_por | input | 1 | Power-on reset strobe |
| evt_lv1 | input | 1 | Threshold 1 supply-monitor reset strobe |
| evt_lv2 | input | 1 | Threshold 2 supply-monitor reset strobe |
| evt_dstby | input | 1 | Deep-standby wake reset strobe |
| evt_iwdt | input | 1 | Independent watchdog underflow reset strobe |
| evt_wdt | input | 1 | Watchdog overflow reset strobe |
| evt_pin | input | 1 | External pin reset strobe |
| wr_valid | input | 1 | Clear-write beat valid |
| wr_ready | output | 1 | Clear-write ready, constantly 1 |
| wr_sel | input | 1 | 0 addresses the status byte, 1 the watchdog byte |
| wr_data | input | 8 | Clear mask, active-low per flag |
| stat_byte | output | 8 | Status byte: bit 7 deep-standby, 2 threshold 2, 1 threshold 1, 0 power-on |
| wdg_byte | output | 8 | Watchdog byte: bit 1 watchdog, bit 0 independent watchdog |
| cause | output | 3 | Priority-encoded primary cause code |

## Verification
Flags are held in registers and the outputs decode them directly. A wrong flag therefore shows on `stat_byte` or `wdg_byte` one cycle after the strobe or write that caused it. It also shows on `cause` in that same cycle whenever the flag is the highest priority one set. The bench checks these outputs after every stimulus. A wrong ordering of the wipe, set and clear steps shows up only when those steps coincide, so the bench drives each such pairing in a single cycle. It also clears flags one at a time from a fully set state, so that every priority boundary of the cause code is observed.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  localparam int NFLAG  = 6;
  localparam int BYTE_W = 8;
  localparam int CODE_W = 3;

  // Internal flag index, ascending with priority.
  localparam int F_POR   = 0;
  localparam int F_LV1   = 1;
  localparam int F_LV2   = 2;
  localparam int F_DSTBY = 3;
  localparam int F_IWDT  = 4;
  localparam int F_WDT   = 5;

  // Software-visible bit positions.
  localparam int SB_POR   = 0;
  localparam int SB_LV1   = 1;
  localparam int SB_LV2   = 2;
  localparam int SB_DSTBY = 7;
  localparam int WB_IWDT  = 0;
  localparam int WB_WDT   = 1;

  typedef enum logic [CODE_W-1:0] {
    CAUSE_PIN   = 3'd0,
    CAUSE_POR   = 3'd1,
    CAUSE_LV1   = 3'd2,
    CAUSE_LV2   = 3'd3,
    CAUSE_DSTBY = 3'd4,
    CAUSE_IWDT  = 3'd5,
    CAUSE_WDT   = 3'd6
  } cause_e;
endpackage

// File: rtl/rcs_clear_decode.sv
module rcs_clear_decode
  import rcs_pkg::*;
(
  input  logic              wr_valid,
  input  logic              wr_sel,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [NFLAG-1:0]  clr_mask
);
  logic stat_beat;
  logic wdg_beat;

  assign stat_beat = wr_valid && !wr_sel;
  assign wdg_beat  = wr_valid &&  wr_sel;

  always_comb begin
    clr_mask          = '0;
    clr_mask[F_POR]   = stat_beat && !wr_data[SB_POR];
    clr_mask[F_LV1]   = stat_beat && !wr_data[SB_LV1];
    clr_mask[F_LV2]   = stat_beat && !wr_data[SB_LV2];
    clr_mask[F_DSTBY] = stat_beat && !wr_data[SB_DSTBY];
    clr_mask[F_IWDT]  = wdg_beat  && !wr_data[WB_IWDT];
    clr_mask[F_WDT]   = wdg_beat  && !wr_data[WB_WDT];
  end
endmodule

// File: rtl/rcs_next_state.sv
module rcs_next_state
  import rcs_pkg::*;
(
  input  logic [NFLAG-1:0] flags,
  input  logic [NFLAG-1:0] clr_mask,
  input  logic [NFLAG-1:0] ev,
  input  logic             ev_pin,
  output logic [NFLAG-1:0] nxt
);
  logic [NFLAG-1:0] set_mask;
  logic             other_src;

  always_comb begin
    set_mask        = ev;
    set_mask[F_POR] = 1'b0;
  end
  assign other_src = |set_mask;

  always_comb begin
    nxt = flags & ~clr_mask;           // software clear first
    if (ev_pin)
      nxt = '0;                        // pin wipes everything
    if (ev[F_POR]) begin
      nxt        = '0;                 // power-on starts fresh
      nxt[F_POR] = 1'b1;
    end
    nxt = nxt | set_mask;              // events beat clears
    if (other_src)
      nxt[F_POR] = 1'b0;               // any other cause drops power-on
  end
endmodule

// File: rtl/rcs_cause_enc.sv
module rcs_cause_enc
  import rcs_pkg::*;
#(
  parameter int N = NFLAG,
  parameter int W = CODE_W
) (
  input  logic [N-1:0] flags,
  output logic [W-1:0] code
);
  always_comb begin
    code = '0;
    for (int i = 0; i < N; i++)
      if (flags[i])
        code = W'(i + 1);
  end
endmodule

// File: rtl/rcs_status.sv
module rcs_status
  import rcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_por,
  input  logic              evt_lv1,
  input  logic              evt_lv2,
  input  logic              evt_dstby,
  input  logic              evt_iwdt,
  input  logic              evt_wdt,
  input  logic              evt_pin,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic              wr_sel,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] stat_byte,
  output logic [BYTE_W-1:0] wdg_byte,
  output logic [CODE_W-1:0] cause
);
  logic [NFLAG-1:0] ev;
  logic [NFLAG-1:0] clr_mask;
  logic [NFLAG-1:0] nxt;
  logic [NFLAG-1:0] flags;

  assign ev       = {evt_wdt, evt_iwdt, evt_dstby, evt_lv2, evt_lv1, evt_por};
  assign wr_ready = 1'b1;

  rcs_clear_decode u_dec (
    .wr_valid (wr_valid),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .clr_mask (clr_mask)
  );

  rcs_next_state u_nxt (
    .flags    (flags),
    .clr_mask (clr_mask),
    .ev       (ev),
    .ev_pin   (evt_pin),
    .nxt      (nxt)
  );

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags[g] <= 1'b0;
      else        flags[g] <= nxt[g];
    end
  end

  always_comb begin
    stat_byte           = '0;
    stat_byte[SB_POR]   = flags[F_POR];
    stat_byte[SB_LV1]   = flags[F_LV1];
    stat_byte[SB_LV2]   = flags[F_LV2];
    stat_byte[SB_DSTBY] = flags[F_DSTBY];
    wdg_byte            = '0;
    wdg_byte[WB_IWDT]   = flags[F_IWDT];
    wdg_byte[WB_WDT]    = flags[F_WDT];
  end

  rcs_cause_enc #(.N(NFLAG), .W(CODE_W)) u_enc (
    .flags (flags),
    .code  (cause)
  );
endmodule

// File: rtl/rcs_status_chk.sv
module rcs_status_chk
  import rcs_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              evt_por,
  input logic              evt_lv1,
  input logic              evt_lv2,
  input logic              evt_dstby,
  input logic              evt_iwdt,
  input logic              evt_wdt,
  input logic              evt_pin,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic              wr_sel,
  input logic [BYTE_W-1:0] wr_data,
  input logic [BYTE_W-1:0] stat_byte,
  input logic [BYTE_W-1:0] wdg_byte,
  input logic [CODE_W-1:0] cause
);
  logic other_src;
  assign other_src = evt_lv1 | evt_lv2 | evt_dstby | evt_iwdt | evt_wdt;

  assert_por_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_por && !other_src) |=> (stat_byte == 8'h01 && wdg_byte == 8'h00));

  assert_lv1_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    evt_lv1 |=> stat_byte[1]);

  assert_por_dropped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    other_src |=> !stat_byte[0]);

  assert_pin_wipes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_pin && !evt_por && !other_src) |=> (stat_byte == 8'h00 && wdg_byte == 8'h00));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_valid && !evt_pin && !evt_por && !other_src) |=> ($stable(stat_byte) && $stable(wdg_byte)));

  assert_wdt_top_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wdg_byte[1] |-> cause == 3'd6);

  assert_pin_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_byte == 8'h00 && wdg_byte == 8'h00) |-> cause == 3'd0);
endmodule

bind rcs_status rcs_status_chk u_chk (.*);

// File: tb/sim_rcs_status.sv
`timescale 1ns/1ps
module sim_rcs_status;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       evt_por = 0, evt_lv1 = 0, evt_lv2 = 0, evt_dstby = 0;
  logic       evt_iwdt = 0, evt_wdt = 0, evt_pin = 0;
  logic       wr_valid = 0, wr_sel = 0;
  logic [7:0] wr_data = 8'h00;
  logic       wr_ready;
  logic [7:0] stat_byte, wdg_byte;
  logic [2:0] cause;

  int n_run = 0;
  int n_fail = 0;
  // model flags: [0]por [1]lv1 [2]lv2 [3]dstby [4]iwdt [5]wdt
  logic [5:0] m = '0;

  always #2.5 clk = ~clk;

  rcs_status u0 (.*);

  function automatic logic [2:0] exp_cause(input logic [5:0] f);
    if (f[5]) return 3'd6;
    if (f[4]) return 3'd5;
    if (f[3]) return 3'd4;
    if (f[2]) return 3'd3;
    if (f[1]) return 3'd2;
    if (f[0]) return 3'd1;
    return 3'd0;
  endfunction

  task automatic check(input string tag);
    logic [7:0] es, ew;
    logic [2:0] ec;
    es = {m[3], 4'b0000, m[2], m[1], m[0]};
    ew = {6'b000000, m[5], m[4]};
    ec = exp_cause(m);
    n_run++;
    if (stat_byte !== es || wdg_byte !== ew || cause !== ec || wr_ready !== 1'b1) begin
      n_fail++;
      $display("FAIL %s: stat=%h wdg=%h cause=%0d rdy=%b expected stat=%h wdg=%h cause=%0d rdy=1",
               tag, stat_byte, wdg_byte, cause, wr_ready, es, ew, ec);
    end
  endtask

  // e = {pin, wdt, iwdt, dstby, lv2, lv1, por}
  task automatic step(input logic [6:0] e, input logic wv, input logic sel, input logic [7:0] d);
    logic [5:0] clr;
    clr = '0;
    if (wv && !sel) clr[3:0] = ~{d[7], d[2], d[1], d[0]};
    if (wv &&  sel) clr[5:4] = ~d[1:0];
    m = m & ~clr;
    if (e[6]) m = '0;
    if (e[0]) m = 6'b000001;
    m = m | {e[5:1], 1'b0};
    if (|e[5:1]) m[0] = 1'b0;
    @(negedge clk);
    {evt_pin, evt_wdt, evt_iwdt, evt_dstby, evt_lv2, evt_lv1, evt_por} = e;
    wr_valid = wv; wr_sel = sel; wr_data = d;
    @(negedge clk);
    {evt_pin, evt_wdt, evt_iwdt, evt_dstby, evt_lv2, evt_lv1, evt_por} = '0;
    wr_valid = 0; wr_sel = 0; wr_data = 8'h00;
  endtask

  task automatic t_reset;
    check("R1 reset state");
    check("R9 unused bits zero after reset");
  endtask

  task automatic t_por;
    step(7'b0000110, 0, 0, 8'h00);  // lv1+lv2
    step(7'b0000001, 0, 0, 8'h00);
    check("R2 power-on sets own flag, clears others");
  endtask

  task automatic t_sources;
    step(7'b0000010, 0, 0, 8'h00); check("R3 threshold 1 sets, clears power-on");
    step(7'b0000100, 0, 0, 8'h00); check("R3 threshold 2 keeps threshold 1");
    step(7'b0001000, 0, 0, 8'h00); check("R3 deep-standby bit 7");
    step(7'b0010000, 0, 0, 8'h00); check("R3 independent watchdog");
    step(7'b0100000, 0, 0, 8'h00); check("R3 watchdog");
    check("R9 unused bits stay zero with all set");
  endtask

  task automatic t_pin;
    step(7'b1000000, 0, 0, 8'h00); check("R4 pin wipes all");
    step(7'b0000001, 0, 0, 8'h00);
    step(7'b1000100, 0, 0, 8'h00); check("R4 pin with threshold 2 same cycle");
  endtask

  task automatic t_stat_clear;
    step(7'b0001110, 0, 0, 8'h00);
    step(7'b0000000, 1, 0, 8'hFB); check("R5 clear threshold 2 only");
    step(7'b0000000, 1, 0, 8'h79); check("R5 clear deep-standby, bits 6:3 ignored");
    step(7'b0110000, 0, 0, 8'h00);
    step(7'b0000000, 1, 0, 8'h00); check("R5 status clear leaves watchdog byte");
  endtask

  task automatic t_wdg_clear;
    step(7'b0000110, 0, 0, 8'h00);
    step(7'b0000000, 1, 1, 8'hFD); check("R6 clear watchdog bit 1");
    step(7'b0000000, 1, 1, 8'h00); check("R6 clear independent, status untouched");
  endtask

  task automatic t_race;
    step(7'b0000000, 1, 0, 8'h00);
    step(7'b0000010, 1, 0, 8'h00); check("R7 threshold 1 beats clear");
    step(7'b0100000, 1, 1, 8'h00); check("R7 watchdog beats clear");
  endtask

  task automatic t_priority;
    step(7'b0000000, 1, 0, 8'h00);
    step(7'b0000000, 1, 1, 8'h00);
    step(7'b0000001, 0, 0, 8'h00); check("R8 power-on only gives 1");
    step(7'b0111110, 0, 0, 8'h00); check("R8 all set gives watchdog");
    step(7'b0000000, 1, 1, 8'hFD); check("R8 independent watchdog next");
    step(7'b0000000, 1, 1, 8'hFC); check("R8 deep-standby next");
    step(7'b0000000, 1, 0, 8'h7F); check("R8 threshold 2 next");
    step(7'b0000000, 1, 0, 8'h7B); check("R8 threshold 1 next");
    step(7'b0000000, 1, 0, 8'h79); check("R8 none set gives pin");
  endtask

  task automatic t_valid;
    step(7'b0011110, 0, 0, 8'h00);
    @(negedge clk); wr_valid = 0; wr_sel = 0; wr_data = 8'h00;
    @(negedge clk); wr_sel = 1;
    @(negedge clk); wr_sel = 0;
    check("R10 data without valid ignored");
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_por();
    t_sources();
    t_pin();
    t_stat_clear();
    t_wdg_clear();
    t_race();
    t_priority();
    t_valid();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule